// File: doc/BRIEF.md
# Register access bridge over a serial peripheral link

This block lets a host microcontroller reach a small on-chip register file over a four-wire serial link in clock mode 0. Each 16-bit word the host shifts in names a register and carries a value to write. The block returns that register's contents in the same word, taken before the write. The first byte of a word is a command (a write flag above a 7-bit address) and the second byte is the data. Keeping chip select low after the first word starts a burst. Each further word moves to the next address, and the address field of those words is not used.

Event inputs set sticky status flags, and the host clears them by writing ones. A frozen copy of the flags is taken the moment chip select goes low. Every status read in that burst returns the frozen copy, so events that arrive during the burst and clears made earlier in it cannot alter what the host reads. Writes land only once the last bit of a word is in, so no word can see its own write.

The write strobe is a plain one-cycle pulse with no back-pressure: the logic behind it must accept a write on any cycle. The serial pins are sampled by the system clock through two-flop synchronisers, so the serial clock must run well below a quarter of the system clock rate.

Top module: `spi_regbank_slave`

## Requirements
- R1: A word is 16 bits, most significant bit first, with data in sampled on the rising serial clock edge. Bit 15 is the write flag, bits 14:8 are the address and bits 7:0 are the write value.
- R2: During the data byte, the data out pin shifts out the addressed register's value from before that word's write, most significant bit first, with each bit changing after a falling serial clock edge. During the command byte the pin is 0.
- R3: Addresses 0 to 7 are read/write control registers, with register n on ctrl_q bits 8n+7:8n. Addresses 16 and 17 read status flag bits 7:0 and 15:8 respectively, and writing ones to them clears those flags. Every other address reads 0, and a write to it changes no register.
- R4: Once the 16th bit of a write word is in, the control register takes the new value, and wr_stb is high for exactly one system clock with wr_addr and wr_data holding that word's address and value. Read words give no strobe.
- R5: Within one chip-select-low period, each word after the first uses the previous word's address plus one, wrapping from 127 to 0, and ignores its own address field. Its write flag still applies.
- R6: A high sts_evt bit sets the matching sts_live flag on the next clock, and a set takes priority over a clear in the same cycle. The flag stays set until the host clears it.
- R7: The status flags are copied when chip select falls. Every status read until chip select rises returns that copy, even after events or clears during the burst.
- R8: spi_miso_oe is high only while the synchronised chip select is low, and spi_miso is 0 whenever it is low.
- R9: Raising chip select partway through a word drops that word without a write. The next transfer starts again with a command byte.
- R10: Under reset all control registers and flags are 0, and wr_stb and spi_miso_oe are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| spi_sclk | input | 1 | Serial clock from the host, idle low |
| spi_cs_n | input | 1 | Chip select from the host, active low |
| spi_mosi | input | 1 | Serial data from the host |
| spi_miso | output | 1 | Serial data to the host |
| spi_miso_oe | output | 1 | Output enable for the data-out pad |
| sts_evt | input | 16 | Event pulses that set status flags |
| sts_live | output | 16 | Current status flags |
| ctrl_q | output | 64 | Eight control registers, packed |
| wr_stb | output | 1 | One-cycle write strobe |
| wr_addr | output | 7 | Address of the completed write |
| wr_data | output | 8 | Value of the completed write |

## Verification
The assertions check on every cycle that the write strobe is one cycle wide, that a control register changes only on a strobe cycle, that each event sets its flag, that no flag rises without an event, and that the status copy holds still once a burst has begun. Only the bench's scenarios can show that the returned byte is the value from before the write, that the address advances and wraps across a burst of more than 128 words, that a clear and a new event made during a burst stay hidden until the next one, and that an aborted partial word leaves no trace.

// File: rtl/spi_rb_pkg.sv
package spi_rb_pkg;
  localparam int unsigned DEF_ADDR_W    = 7;
  localparam int unsigned DEF_DATA_W    = 8;
  localparam int unsigned DEF_NUM_CTRL  = 8;
  localparam int unsigned DEF_STS_BASE  = 16;
  localparam int unsigned DEF_STS_BYTES = 2;
  localparam int unsigned DEF_SYNC_LEN  = 2;

  // true when a lies in [base, base+n)
  function automatic bit in_window(int unsigned a, int unsigned base, int unsigned n);
    return (a >= base) && (a < base + n);
  endfunction
endpackage

// File: rtl/spi_rb_sync.sv
module spi_rb_sync #(
  parameter int unsigned W      = 3,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) stage_q[s] <= RST_VAL;
    end else begin
      stage_q[0] <= d;
      for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
    end
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/spi_rb_edge.sv
module spi_rb_edge #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic chg
);
  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= RST_VAL;
    else        prev_q <= d;
  end

  assign chg = d ^ prev_q;
endmodule

// File: rtl/spi_rb_shifter.sv
module spi_rb_shifter #(
  parameter int unsigned ADDR_W = 7,
  parameter int unsigned DATA_W = 8,
  localparam int unsigned CMD_W  = ADDR_W + 1,
  localparam int unsigned WORD_W = CMD_W + DATA_W,
  localparam int unsigned CNT_W  = $clog2(WORD_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_act,
  input  logic              sclk_rise,
  input  logic              sclk_fall,
  input  logic              mosi_s,
  input  logic [DATA_W-1:0] rd_byte,
  output logic              cmd_done,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic              word_done,
  output logic [WORD_W-1:0] word,
  output logic              miso_bit
);
  logic [CNT_W-1:0]  cnt_q;
  logic [WORD_W-1:0] rx_q;
  logic [DATA_W-1:0] tx_q;

  assign cmd_done  = cs_act && sclk_rise && (cnt_q == CNT_W'(CMD_W - 1));
  assign word_done = cs_act && sclk_rise && (cnt_q == CNT_W'(WORD_W - 1));
  assign cmd_addr  = {rx_q[ADDR_W-2:0], mosi_s};
  assign word      = {rx_q[WORD_W-2:0], mosi_s};
  assign miso_bit  = tx_q[DATA_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      rx_q  <= '0;
      tx_q  <= '0;
    end else if (!cs_act) begin
      cnt_q <= '0;
      tx_q  <= '0;
    end else begin
      if (sclk_rise) begin
        rx_q  <= word;
        cnt_q <= word_done ? '0 : cnt_q + 1'b1;
      end
      if (cmd_done)
        tx_q <= rd_byte;
      else if (word_done)
        tx_q <= '0;
      else if (sclk_fall && cnt_q > CNT_W'(CMD_W))
        tx_q <= {tx_q[DATA_W-2:0], 1'b0};
    end
  end
endmodule

// File: rtl/spi_rb_status.sv
module spi_rb_status #(
  parameter int unsigned STS_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [STS_W-1:0] evt,
  input  logic [STS_W-1:0] clr,
  input  logic             take_snap,
  output logic [STS_W-1:0] flags,
  output logic [STS_W-1:0] snap
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags <= '0;
      snap  <= '0;
    end else begin
      flags <= (flags & ~clr) | evt;
      if (take_snap) snap <= flags;
    end
  end
endmodule

// File: rtl/spi_regbank_slave.sv
module spi_regbank_slave
  import spi_rb_pkg::*;
#(
  parameter int unsigned ADDR_W    = DEF_ADDR_W,
  parameter int unsigned DATA_W    = DEF_DATA_W,
  parameter int unsigned NUM_CTRL  = DEF_NUM_CTRL,
  parameter int unsigned STS_BASE  = DEF_STS_BASE,
  parameter int unsigned STS_BYTES = DEF_STS_BYTES,
  parameter int unsigned SYNC_LEN  = DEF_SYNC_LEN,
  localparam int unsigned CMD_W    = ADDR_W + 1,
  localparam int unsigned WORD_W   = CMD_W + DATA_W,
  localparam int unsigned STS_W    = STS_BYTES * DATA_W,
  localparam int unsigned CTRL_W   = NUM_CTRL * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spi_sclk,
  input  logic              spi_cs_n,
  input  logic              spi_mosi,
  output logic              spi_miso,
  output logic              spi_miso_oe,
  input  logic [STS_W-1:0]  sts_evt,
  output logic [STS_W-1:0]  sts_live,
  output logic [CTRL_W-1:0] ctrl_q,
  output logic              wr_stb,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data
);
  // synchronised pins: {cs_n, sclk, mosi}
  logic [2:0] pins_s;
  logic       cs_act, sclk_s, mosi_s;
  logic       cs_chg, sclk_chg, cs_start, sclk_rise, sclk_fall;

  spi_rb_sync #(.W(3), .STAGES(SYNC_LEN), .RST_VAL(3'b100)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({spi_cs_n, spi_sclk, spi_mosi}), .q(pins_s));

  assign cs_act = ~pins_s[2];
  assign sclk_s = pins_s[1];
  assign mosi_s = pins_s[0];

  spi_rb_edge #(.RST_VAL(1'b0)) u_cs_edge (
    .clk(clk), .rst_n(rst_n), .d(cs_act), .chg(cs_chg));
  spi_rb_edge #(.RST_VAL(1'b0)) u_sclk_edge (
    .clk(clk), .rst_n(rst_n), .d(sclk_s), .chg(sclk_chg));

  assign cs_start  = cs_chg & cs_act;
  assign sclk_rise = sclk_chg & sclk_s;
  assign sclk_fall = sclk_chg & ~sclk_s;

  // word framing
  logic              cmd_done, word_done, miso_bit;
  logic [ADDR_W-1:0] cmd_field;
  logic [WORD_W-1:0] word;
  logic [DATA_W-1:0] rd_byte;

  spi_rb_shifter #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .cs_act(cs_act),
    .sclk_rise(sclk_rise), .sclk_fall(sclk_fall), .mosi_s(mosi_s),
    .rd_byte(rd_byte), .cmd_done(cmd_done), .cmd_addr(cmd_field),
    .word_done(word_done), .word(word), .miso_bit(miso_bit));

  assign spi_miso_oe = cs_act;
  assign spi_miso    = cs_act & miso_bit;

  // burst addressing
  logic              first_q;
  logic [ADDR_W-1:0] next_q, word_addr_q, cur_addr;
  logic              word_we;
  logic [DATA_W-1:0] word_val;

  assign cur_addr = first_q ? cmd_field : next_q;
  assign word_we  = word[WORD_W-1];
  assign word_val = word[DATA_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      first_q     <= 1'b1;
      next_q      <= '0;
      word_addr_q <= '0;
      wr_stb      <= 1'b0;
      wr_addr     <= '0;
      wr_data     <= '0;
    end else begin
      wr_stb <= 1'b0;
      if (!cs_act) begin
        first_q <= 1'b1;
      end else begin
        if (cmd_done) word_addr_q <= cur_addr;
        if (word_done) begin
          first_q <= 1'b0;
          next_q  <= word_addr_q + 1'b1;
          if (word_we) begin
            wr_stb  <= 1'b1;
            wr_addr <= word_addr_q;
            wr_data <= word_val;
          end
        end
      end
    end
  end

  // status flags and frozen copy
  logic [STS_W-1:0] sts_clr, snap;

  always_comb begin
    sts_clr = '0;
    for (int j = 0; j < STS_BYTES; j++)
      if (word_done && word_we && word_addr_q == ADDR_W'(STS_BASE + j))
        sts_clr[j*DATA_W +: DATA_W] = word_val;
  end

  spi_rb_status #(.STS_W(STS_W)) u_status (
    .clk(clk), .rst_n(rst_n), .evt(sts_evt), .clr(sts_clr),
    .take_snap(cs_start), .flags(sts_live), .snap(snap));

  // control registers
  logic [DATA_W-1:0] ctrl_r [NUM_CTRL];

  for (genvar i = 0; i < NUM_CTRL; i++) begin : g_ctrl
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        ctrl_r[i] <= '0;
      else if (word_done && word_we && word_addr_q == ADDR_W'(i))
        ctrl_r[i] <= word_val;
    end
    assign ctrl_q[i*DATA_W +: DATA_W] = ctrl_r[i];
  end

  // read selection, taken when the command byte completes
  always_comb begin
    rd_byte = '0;
    for (int i = 0; i < NUM_CTRL; i++)
      if (cur_addr == ADDR_W'(i)) rd_byte = ctrl_r[i];
    for (int j = 0; j < STS_BYTES; j++)
      if (in_window(int'(cur_addr), STS_BASE, STS_BYTES) && cur_addr == ADDR_W'(STS_BASE + j))
        rd_byte = snap[j*DATA_W +: DATA_W];
  end
endmodule

// File: rtl/spi_regbank_chk.sv
module spi_regbank_chk #(
  parameter int unsigned STS_W  = 16,
  parameter int unsigned CTRL_W = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_stb,
  input logic [CTRL_W-1:0] ctrl_q,
  input logic [STS_W-1:0]  sts_evt,
  input logic [STS_W-1:0]  sts_live,
  input logic              cs_act,
  input logic [STS_W-1:0]  snap
);
  // R4
  strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> !wr_stb);

  // R4
  ctrl_needs_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ctrl_q) |-> wr_stb);

  // R6
  event_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_evt != '0) |=> ((sts_live & $past(sts_evt)) == $past(sts_evt)));

  // R6
  no_stray_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((sts_live & ~$past(sts_live) & ~$past(sts_evt)) == '0));

  // R7
  snap_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_act && $past(cs_act) && $past(cs_act, 2)) |-> $stable(snap));
endmodule

bind spi_regbank_slave spi_regbank_chk #(.STS_W(STS_W), .CTRL_W(CTRL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .ctrl_q(ctrl_q),
  .sts_evt(sts_evt), .sts_live(sts_live), .cs_act(cs_act), .snap(snap));

// File: tb/spi_regbank_slave_tb_top.sv
module spi_regbank_slave_tb_top;
  localparam int NCTRL = 8, SBASE = 16, SBYTES = 2, HP = 4;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n = 1'b0, sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0;
  logic [15:0] evt = '0;
  logic        miso, miso_oe, stb;
  logic [15:0] live;
  logic [63:0] ctrl;
  logic [6:0]  waddr;
  logic [7:0]  wdata;

  spi_regbank_slave dut_i (
    .clk(clk), .rst_n(rst_n), .spi_sclk(sclk), .spi_cs_n(cs_n), .spi_mosi(mosi),
    .spi_miso(miso), .spi_miso_oe(miso_oe), .sts_evt(evt), .sts_live(live),
    .ctrl_q(ctrl), .wr_stb(stb), .wr_addr(waddr), .wr_data(wdata));

  int total = 0, bad = 0;
  bit stable = 0;
  logic [7:0]  ctrl_m [NCTRL];
  logic [15:0] flags_m = '0, snap_m = '0;
  int          stb_cnt = 0;
  logic [6:0]  stb_addr = '0;
  logic [7:0]  stb_data = '0;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp, string what);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // per-clock comparison against the reference model
  always @(posedge clk) begin
    #2;
    if (rst_n) begin
      if (stb) begin
        stb_cnt++;
        stb_addr = waddr;
        stb_data = wdata;
      end
      if (stable) begin
        for (int i = 0; i < NCTRL; i++) chk("R4", ctrl[i*8 +: 8], ctrl_m[i], "control register");
        chk("R6", live, flags_m, "live flags");
      end
    end
  end

  function automatic logic [7:0] exp_read(int a);
    if (a < NCTRL) return ctrl_m[a];
    if (a >= SBASE && a < SBASE + SBYTES) return snap_m[(a - SBASE)*8 +: 8];
    return 8'h00;
  endfunction

  task automatic spi_word(bit we, logic [6:0] af, logic [7:0] d,
                          output logic [7:0] rd, output logic [7:0] cm);
    logic [15:0] w;
    w = {we, af, d};
    for (int i = 15; i >= 0; i--) begin
      mosi = w[i];
      repeat (HP) @(negedge clk);
      if (i < 8) rd[i] = miso; else cm[i-8] = miso;
      sclk = 1'b1;
      repeat (HP) @(negedge clk);
      sclk = 1'b0;
    end
    repeat (HP) @(negedge clk);
  endtask

  task automatic cs_begin();
    cs_n = 1'b0;
    snap_m = flags_m;
    repeat (HP) @(negedge clk);
    chk("R8", miso_oe, 1, "output enable while selected");
  endtask

  task automatic cs_end();
    cs_n = 1'b1;
    repeat (HP) @(negedge clk);
    chk("R8", miso_oe, 0, "output enable while idle");
    chk("R8", miso, 0, "data out while idle");
  endtask

  task automatic do_word(string req, int cur, bit we, logic [6:0] af, logic [7:0] d);
    logic [7:0] rd, cm, exp;
    int s0;
    exp = exp_read(cur);
    s0 = stb_cnt;
    stable = 0;
    spi_word(we, af, d, rd, cm);
    chk(req, rd, exp, "returned byte (R2 old value)");
    chk("R2", cm, 0, "data out during command byte");
    if (we) begin
      chk("R4", stb_cnt, s0 + 1, "strobe count");
      chk("R4", stb_addr, cur, "strobe address");
      chk("R4", stb_data, d, "strobe data");
      if (cur < NCTRL) ctrl_m[cur] = d;
      else if (cur >= SBASE && cur < SBASE + SBYTES) flags_m[(cur - SBASE)*8 +: 8] &= ~d;
    end else begin
      chk("R4", stb_cnt, s0, "no strobe on read word");
    end
    stable = 1;
  endtask

  task automatic pulse_evt(logic [15:0] m);
    stable = 0;
    evt = m;
    @(negedge clk);
    evt = '0;
    flags_m |= m;
    repeat (2) @(negedge clk);
    stable = 1;
  endtask

  initial begin
    for (int i = 0; i < NCTRL; i++) ctrl_m[i] = 8'h00;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10", ctrl, 0, "control registers in reset");
    chk("R10", live, 0, "flags in reset");
    chk("R10", stb, 0, "strobe in reset");
    chk("R10", miso_oe, 0, "output enable in reset");
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    stable = 1;

    // R1/R2 single write then read back
    cs_begin();
    do_word("R1", 3, 1'b1, 7'd3, 8'hA5);
    cs_end();
    cs_begin();
    do_word("R2", 3, 1'b0, 7'd3, 8'h00);
    cs_end();

    // R5 burst write with ignored address fields, then burst read
    cs_begin();
    for (int k = 0; k < NCTRL; k++)
      do_word(k == 0 ? "R1" : "R5", k, 1'b1, k == 0 ? 7'd0 : 7'h55, 8'(8'h10 + k*3));
    cs_end();
    cs_begin();
    for (int k = 0; k < NCTRL; k++)
      do_word("R5", k, 1'b0, k == 0 ? 7'd0 : 7'h6B, 8'hFF);
    cs_end();

    // R3 unmapped addresses
    cs_begin();
    do_word("R3", 64, 1'b1, 7'd64, 8'hEE);
    do_word("R3", 65, 1'b0, 7'd0, 8'h00);
    cs_end();
    for (int i = 0; i < NCTRL; i++) chk("R3", ctrl[i*8 +: 8], ctrl_m[i], "unmapped write left register");

    // R6/R7 status copy through a wrapping burst
    pulse_evt(16'h0103);
    chk("R6", live, 16'h0103, "flags after events");
    cs_begin();
    do_word("R7", 16, 1'b1, 7'd16, 8'hFF);
    chk("R3", live, 16'h0100, "write-one clear of low byte");
    pulse_evt(16'h0200);
    do_word("R7", 17, 1'b0, 7'h00, 8'h00);
    for (int a = 18; a < 128 + 16; a++)
      do_word("R5", a % 128, 1'b0, 7'h2A, 8'h00);
    do_word("R7", 16, 1'b0, 7'h00, 8'h00);
    do_word("R7", 17, 1'b0, 7'h00, 8'h00);
    cs_end();
    cs_begin();
    do_word("R7", 16, 1'b0, 7'd16, 8'h00);
    do_word("R7", 17, 1'b0, 7'h00, 8'h00);
    cs_end();
    chk("R7", snap_m, 16'h0300, "new copy holds later event");

    // R9 aborted partial word
    begin
      int s0;
      logic [15:0] w;
      s0 = stb_cnt;
      w = {1'b1, 7'd3, 8'h00};
      cs_begin();
      stable = 0;
      for (int i = 15; i >= 11; i--) begin
        mosi = w[i];
        repeat (HP) @(negedge clk);
        sclk = 1'b1;
        repeat (HP) @(negedge clk);
        sclk = 1'b0;
      end
      stable = 1;
      cs_end();
      repeat (HP) @(negedge clk);
      chk("R9", stb_cnt, s0, "no strobe from aborted word");
      cs_begin();
      do_word("R9", 3, 1'b0, 7'd3, 8'h00);
      cs_end();
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule